// File: doc/BRIEF.md
# Three-Wire Clock-Chip Command Slave

This block is the device end of a three-wire link to a real-time clock: a serial clock, one bidirectional data line and a chip select. A host moves the three lines by writing a 3-bit pin word, one word per strobe, and reads the current line levels back as a 3-bit word. The block works out the start of a transfer from the line levels and shifts in a command byte. It then moves parameter bytes in from the host or out to it.

The command byte names a target register and a direction. It is accepted in either bit order: a fixed 0110 marker nibble shows which order was used. Each register has its own fixed number of parameter bytes. Writes can update a status byte, or clear it through a reset command. Reads return the status byte, or BCD calendar and time bytes. Those bytes are taken from a parallel BCD calendar bus, which a separate timekeeping counter drives.

The pin-word strobe is a plain control input with no back-pressure. The block takes every strobed word in the cycle it arrives. The readback word changes on the clock edge after the strobe. The rejected-command flag is a one-cycle pulse.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset the pin readback word is 000. A status read returns 0x40, which means 24-hour mode set and every other bit clear.
- R2: Readback bit 0 is the serial clock, bit 1 is the data line and bit 2 is the chip select. The data line takes a host-driven value only on a clock falling edge, that is a strobe that takes bit 0 from 1 to 0 while host drive is set.
- R3: A transfer opens only through two steps from idle. First comes a word with clock high and select low, then a word with both high. If both lines go high directly from idle, the serial bits that follow have no effect.
- R4: Data bits are sampled on clock falling edges and assembled LSB first. A command whose low nibble is 0110 is decoded as received. After decoding, bits 6:4 are the register code and bit 7 set means a read.
- R5: A command whose high nibble is 0110 is bit-reversed before decoding. For example, 0x62 is a status write and 0x63 is a status read.
- R6: Any other command pattern, or the unused register codes 1 and 5, pulses `cmd_reject` and returns the block to idle.
- R7: A status write (code 4, one byte) keeps only bit 3 (minute interrupt enable), bit 6 (24-hour mode) and bit 7 (power-off). For example, writing 0xFF reads back as 0xC8.
- R8: A date-time read (code 2) sends seven BCD bytes in this order: year, month, day, weekday, hour, minute, second.
- R9: A time read (code 6) sends three BCD bytes: hour, minute, second.
- R10: When status bit 6 is clear, the reported hour is the 12-hour value minus one. So hour 17 reads 0x04, hours 00 and 12 read 0x11, and hour 13 reads 0x00.
- R11: The reset command (code 0, no bytes) clears the status byte and returns to idle.
- R12: Writes to the date-time and time registers are taken and discarded. The interrupt and free commands (codes 3 and 7, no bytes) change nothing.
- R13: Dropping chip select during command, receive or send returns the block to idle, and a partial byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_we | input | 1 | Strobe for one pin word |
| pin_wdata | input | 3 | Pin word: {select, data, clock} |
| sio_host_drive | input | 1 | Host drives the data line (1) or releases it to the block (0) |
| cal_year | input | 8 | BCD year, last two digits |
| cal_month | input | 8 | BCD month |
| cal_day | input | 8 | BCD day |
| cal_wday | input | 8 | BCD weekday, Monday = 1 |
| cal_hour | input | 8 | BCD hour, 24-hour form |
| cal_min | input | 8 | BCD minute |
| cal_sec | input | 8 | BCD second |
| pin_rdata | output | 3 | Line levels: {select, data, clock} |
| cmd_reject | output | 1 | One-cycle pulse on a rejected command |

## Verification
Commands are sent both LSB-first and bit-reversed. This shows that the marker nibble, and not a fixed order, selects how the byte is decoded. Status reads are run after masked writes, after a reset command, after discarded calendar writes and after aborted transfers. Each of these reads gives a value that differs from what a block missing that behaviour would return. The 12-hour reads use hours 17, 00, 12 and 13, which covers the wrap case apart from the simple subtraction. A start with both lines high at once, and a chip-select drop in the middle of a byte, both show whether the framing rules are enforced.

// File: rtl/rtc_link_pkg.sv
package rtc_link_pkg;
  localparam int PIN_W      = 3;
  localparam int BYTE_W     = 8;
  localparam logic [3:0] CMD_MARK = 4'b0110;
  localparam logic [7:0] STATUS_KEEP = 8'hC8;
  localparam logic [7:0] STATUS_INIT = 8'h40;

  localparam logic [2:0] REG_RESET  = 3'd0;
  localparam logic [2:0] REG_DTIME  = 3'd2;
  localparam logic [2:0] REG_IRQ    = 3'd3;
  localparam logic [2:0] REG_STATUS = 3'd4;
  localparam logic [2:0] REG_TIME   = 3'd6;
  localparam logic [2:0] REG_FREE   = 3'd7;

  typedef enum logic [2:0] {
    LK_IDLE, LK_WAIT, LK_CMD, LK_RX, LK_TX
  } link_state_e;

  function automatic logic [2:0] param_bytes(input logic [2:0] code);
    case (code)
      REG_DTIME:  param_bytes = 3'd7;
      REG_STATUS: param_bytes = 3'd1;
      REG_TIME:   param_bytes = 3'd3;
      default:    param_bytes = 3'd0;
    endcase
  endfunction

  function automatic logic code_known(input logic [2:0] code);
    code_known = (code != 3'd1) && (code != 3'd5);
  endfunction
endpackage

// File: rtl/rtc_pin_front.sv
module rtc_pin_front
  import rtc_link_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_we,
  input  logic [PIN_W-1:0] pin_wdata,
  input  logic             sio_host_drive,
  input  logic             tx_en,
  input  logic             tx_bit,
  output logic             sck_now,
  output logic             cs_now,
  output logic             sck_fall,
  output logic             bit_now,
  output logic [PIN_W-1:0] pin_rdata
);
  logic sck_q, sio_q, cs_q;

  assign sck_now  = pin_we ? pin_wdata[0] : sck_q;
  assign cs_now   = pin_we ? pin_wdata[2] : cs_q;
  assign sck_fall = pin_we & sck_q & ~pin_wdata[0];
  assign bit_now  = (sck_fall & sio_host_drive) ? pin_wdata[1] : sio_q;
  assign pin_rdata = {cs_q, sio_q, sck_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sio_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      if (pin_we) begin
        sck_q <= pin_wdata[0];
        cs_q  <= pin_wdata[2];
      end
      if (sck_fall && sio_host_drive) sio_q <= pin_wdata[1];
      else if (tx_en)                 sio_q <= tx_bit;
    end
  end

  // R2: the data line holds unless a falling edge or a device bit arrives
  a_r2_sio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pin_we && pin_rdata[0] && !pin_wdata[0]) && !tx_en) |=> $stable(pin_rdata[1]));
  // R2: clock readback follows the strobed word
  a_r2_sck_follow: assert property (@(posedge clk) disable iff (!rst_n)
    pin_we |=> (pin_rdata[0] == $past(pin_wdata[0])));
endmodule

// File: rtl/rtc_hour_fmt.sv
module rtc_hour_fmt
  import rtc_link_pkg::*;
(
  input  logic [BYTE_W-1:0] hour_bcd,
  input  logic              mode_24h,
  output logic [BYTE_W-1:0] hour_out
);
  logic [4:0] bin, wrapped, reduced;
  logic       tens;
  logic [3:0] ones;

  always_comb begin
    bin     = 5'(hour_bcd[7:4]) * 5'd10 + 5'(hour_bcd[3:0]);
    wrapped = (bin >= 5'd12) ? bin - 5'd12 : bin;
    reduced = (wrapped == 5'd0) ? 5'd11 : wrapped - 5'd1;
    tens    = (reduced >= 5'd10);
    ones    = 4'(tens ? reduced - 5'd10 : reduced);
    hour_out = mode_24h ? hour_bcd : {3'b000, tens, ones};
  end

  // R10: a valid 24-hour input always maps into 0x00..0x11 in 12-hour form
  always_comb begin
    if (!mode_24h && hour_bcd <= 8'h23 && hour_bcd[3:0] <= 4'd9)
      a_r10_hour12_range: assert (hour_out <= 8'h11);
  end
endmodule

// File: rtl/rtc_link_fsm.sv
module rtc_link_fsm
  import rtc_link_pkg::*;
#(
  parameter int BUF_BYTES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_we,
  input  logic              sck_now,
  input  logic              cs_now,
  input  logic              sck_fall,
  input  logic              bit_now,
  input  logic [BYTE_W-1:0] snap_year,
  input  logic [BYTE_W-1:0] snap_month,
  input  logic [BYTE_W-1:0] snap_day,
  input  logic [BYTE_W-1:0] snap_wday,
  input  logic [BYTE_W-1:0] snap_hour,
  input  logic [BYTE_W-1:0] snap_min,
  input  logic [BYTE_W-1:0] snap_sec,
  output logic              mode_24h,
  output logic              tx_en,
  output logic              tx_bit,
  output logic              cmd_reject
);
  localparam int IDX_W     = $clog2(BUF_BYTES + 1);
  localparam int BUF_SLOTS = 1 << IDX_W;
  localparam int CNT_W     = $clog2(BYTE_W);

  link_state_e       state;
  logic [BYTE_W-1:0] shreg, status_q;
  logic [CNT_W-1:0]  bitcnt;
  logic [IDX_W-1:0]  byte_idx, byte_cnt;
  logic [2:0]        reg_sel;
  logic [BYTE_W-1:0] xbuf [BUF_SLOTS];

  logic [BYTE_W-1:0] rx8, rx_rev, cmd;
  logic              cmd_ok, cmd_rd, last_bit, abort, snap_load;
  logic [2:0]        cmd_reg;
  logic [IDX_W-1:0]  cmd_cnt;

  assign rx8 = {bit_now, shreg[BYTE_W-1:1]};

  for (genvar g = 0; g < BYTE_W; g++) begin : g_rev
    assign rx_rev[g] = rx8[BYTE_W-1-g];
  end

  always_comb begin
    cmd     = (rx8[3:0] == CMD_MARK) ? rx8 : rx_rev;
    cmd_reg = cmd[6:4];
    cmd_rd  = cmd[7];
    cmd_cnt = IDX_W'(param_bytes(cmd_reg));
    cmd_ok  = ((rx8[3:0] == CMD_MARK) || (rx8[7:4] == CMD_MARK)) && code_known(cmd_reg);
  end

  assign mode_24h  = status_q[6];
  assign last_bit  = (bitcnt == CNT_W'(BYTE_W - 1));
  assign abort     = pin_we && !cs_now &&
                     (state == LK_CMD || state == LK_RX || state == LK_TX);
  assign snap_load = pin_we && cs_now && sck_fall && state == LK_CMD && last_bit &&
                     cmd_ok && cmd_rd && (cmd_cnt != '0);
  assign tx_en     = pin_we && cs_now && sck_fall && state == LK_TX;
  assign tx_bit    = (bitcnt == '0) ? xbuf[byte_idx][0] : shreg[0];

  always_ff @(posedge clk) begin
    if (snap_load) begin
      case (cmd_reg)
        REG_DTIME: begin
          xbuf[0] <= snap_year;  xbuf[1] <= snap_month; xbuf[2] <= snap_day;
          xbuf[3] <= snap_wday;  xbuf[4] <= snap_hour;  xbuf[5] <= snap_min;
          xbuf[6] <= snap_sec;
        end
        REG_TIME: begin
          xbuf[0] <= snap_hour; xbuf[1] <= snap_min; xbuf[2] <= snap_sec;
        end
        default: xbuf[0] <= status_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= LK_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      byte_idx   <= '0;
      byte_cnt   <= '0;
      reg_sel    <= '0;
      status_q   <= STATUS_INIT;
      cmd_reject <= 1'b0;
    end else begin
      cmd_reject <= 1'b0;
      if (abort) begin
        state  <= LK_IDLE;
        bitcnt <= '0;
        shreg  <= '0;
      end else if (pin_we) begin
        case (state)
          LK_IDLE: if (sck_now && !cs_now) state <= LK_WAIT;
          LK_WAIT: if (sck_now && cs_now) begin
            state  <= LK_CMD;
            bitcnt <= '0;
            shreg  <= '0;
          end
          LK_CMD: if (sck_fall) begin
            if (!last_bit) begin
              shreg  <= rx8;
              bitcnt <= bitcnt + 1'b1;
            end else begin
              shreg    <= '0;
              bitcnt   <= '0;
              byte_idx <= '0;
              byte_cnt <= cmd_cnt;
              reg_sel  <= cmd_reg;
              if (!cmd_ok) begin
                cmd_reject <= 1'b1;
                state      <= LK_IDLE;
              end else if (cmd_cnt == '0) begin
                if (cmd_reg == REG_RESET) status_q <= '0;
                state <= LK_IDLE;
              end else begin
                state <= cmd_rd ? LK_TX : LK_RX;
              end
            end
          end
          LK_RX: if (sck_fall) begin
            if (!last_bit) begin
              shreg  <= rx8;
              bitcnt <= bitcnt + 1'b1;
            end else begin
              shreg    <= '0;
              bitcnt   <= '0;
              byte_idx <= byte_idx + 1'b1;
              if (reg_sel == REG_STATUS && byte_idx == '0)
                status_q <= rx8 & STATUS_KEEP;
              if (byte_idx + 1'b1 == byte_cnt) state <= LK_IDLE;
            end
          end
          LK_TX: if (sck_fall) begin
            if (bitcnt == '0) begin
              shreg    <= xbuf[byte_idx] >> 1;
              bitcnt   <= CNT_W'(BYTE_W - 1);
              byte_idx <= byte_idx + 1'b1;
            end else begin
              shreg  <= shreg >> 1;
              bitcnt <= bitcnt - 1'b1;
              if (bitcnt == CNT_W'(1) && byte_idx == byte_cnt) state <= LK_IDLE;
            end
          end
          default: state <= LK_IDLE;
        endcase
      end
    end
  end

  // R6: a rejected command leaves the link idle
  a_r6_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> state == LK_IDLE);
  // R13: a select drop in an active phase always ends in idle
  a_r13_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> state == LK_IDLE);
  // R7: only the three kept status bits can ever be set
  a_r7_status_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~STATUS_KEEP) == '0);
  // R8: the send index never passes the byte count of the register
  a_r8_tx_index: assert property (@(posedge clk) disable iff (!rst_n)
    state == LK_TX |-> byte_idx <= byte_cnt);
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtc_link_pkg::*;
#(
  parameter int BUF_BYTES = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_we,
  input  logic [2:0]       pin_wdata,
  input  logic             sio_host_drive,
  input  logic [7:0]       cal_year,
  input  logic [7:0]       cal_month,
  input  logic [7:0]       cal_day,
  input  logic [7:0]       cal_wday,
  input  logic [7:0]       cal_hour,
  input  logic [7:0]       cal_min,
  input  logic [7:0]       cal_sec,
  output logic [2:0]       pin_rdata,
  output logic             cmd_reject
);
  logic sck_now, cs_now, sck_fall, bit_now, tx_en, tx_bit, mode_24h;
  logic [BYTE_W-1:0] hour_fmt;

  rtc_pin_front u_front (
    .clk, .rst_n, .pin_we, .pin_wdata, .sio_host_drive,
    .tx_en, .tx_bit, .sck_now, .cs_now, .sck_fall, .bit_now, .pin_rdata
  );

  rtc_hour_fmt u_hour (
    .hour_bcd(cal_hour), .mode_24h(mode_24h), .hour_out(hour_fmt)
  );

  rtc_link_fsm #(.BUF_BYTES(BUF_BYTES)) u_fsm (
    .clk, .rst_n, .pin_we, .sck_now, .cs_now, .sck_fall, .bit_now,
    .snap_year(cal_year), .snap_month(cal_month), .snap_day(cal_day),
    .snap_wday(cal_wday), .snap_hour(hour_fmt), .snap_min(cal_min),
    .snap_sec(cal_sec), .mode_24h, .tx_en, .tx_bit, .cmd_reject
  );
endmodule

// File: tb/test_rtc_serial_slave.sv
module test_rtc_serial_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_we = 1'b0, sio_host_drive = 1'b0;
  logic [2:0] pin_wdata = 3'b000;
  logic [7:0] cal_year = 8'h24, cal_month = 8'h07, cal_day = 8'h15, cal_wday = 8'h03;
  logic [7:0] cal_hour = 8'h17, cal_min = 8'h42, cal_sec = 8'h09;
  logic [2:0] pin_rdata;
  logic cmd_reject;

  int checks = 0, fails = 0;
  bit done = 0, reject_seen = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] got_byte;
  event byte_ev;

  always #10 clk = ~clk;

  rtc_serial_slave i_rtc_serial_slave (.*);

  always @(posedge clk) if (cmd_reject) reject_seen <= 1'b1;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // monitor: compares each byte the design sends with the scoreboard head
  initial forever begin
    @(byte_ev);
    if (exp_q.size() == 0) chk(0, "extra byte", got_byte, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(got_byte == e, t, got_byte, e);
    end
  end

  task automatic step(input logic [2:0] w, input bit drv);
    @(negedge clk);
    pin_we = 1'b1; pin_wdata = w; sio_host_drive = drv;
    @(negedge clk);
    pin_we = 1'b0;
  endtask

  task automatic start_xfer();
    step(3'b001, 0);
    step(3'b101, 0);
  endtask

  task automatic end_xfer();
    step(3'b000, 0);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      step({2'b10, 1'b0} | {1'b0, b[i], 1'b0}, 1);
      step({1'b1, b[i], 1'b1}, 1);
    end
  endtask

  task automatic read_cmd(input logic [7:0] c, input int n);
    start_xfer();
    send_byte(c);
    for (int k = 0; k < n; k++) begin
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
        step(3'b100, 0);
        r[i] = pin_rdata[1];
        step(3'b101, 0);
      end
      got_byte = r;
      -> byte_ev;
      #1;
    end
    end_xfer();
  endtask

  task automatic write_cmd(input logic [7:0] c, input logic [7:0] d[], input int n);
    start_xfer();
    send_byte(c);
    for (int k = 0; k < n; k++) send_byte(d[k]);
    end_xfer();
  endtask

  task automatic expect_byte(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] one[];
    logic [7:0] seven[];
    logic [7:0] three[];
    one = new[1];
    seven = '{8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59};
    three = '{8'h01, 8'h02, 8'h03};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pin_rdata == 3'b000, "R1 reset readback", pin_rdata, 0);
    expect_byte(8'h40, "R1 status after reset");
    read_cmd(8'hC6, 1);

    // R3: both lines high straight from idle must not open a transfer
    step(3'b101, 0);
    send_byte(8'h06);
    end_xfer();
    expect_byte(8'h40, "R3 no transfer without wait step");
    read_cmd(8'hC6, 1);

    // R7 and R4: masked status write, LSB-first commands
    one[0] = 8'hFF;
    write_cmd(8'h46, one, 1);
    expect_byte(8'hC8, "R7 status keeps bits 7,6,3");
    read_cmd(8'hC6, 1);

    // R5: bit-reversed commands
    one[0] = 8'h40;
    write_cmd(8'h62, one, 1);
    expect_byte(8'h40, "R5 reversed write and read");
    read_cmd(8'h63, 1);

    // R11: reset command clears status
    write_cmd(8'h06, one, 0);
    expect_byte(8'h00, "R11 status cleared");
    read_cmd(8'hC6, 1);

    // R10: 12-hour form (status now 0x00)
    expect_byte(8'h04, "R10 hour 17 in 12h form");
    expect_byte(8'h42, "R10 minute");
    expect_byte(8'h09, "R10 second");
    read_cmd(8'hE6, 3);
    cal_hour = 8'h00; expect_byte(8'h11, "R10 hour 00"); expect_byte(8'h42, "R10 min"); expect_byte(8'h09, "R10 sec");
    read_cmd(8'hE6, 3);
    cal_hour = 8'h12; expect_byte(8'h11, "R10 hour 12"); expect_byte(8'h42, "R10 min"); expect_byte(8'h09, "R10 sec");
    read_cmd(8'hE6, 3);
    cal_hour = 8'h13; expect_byte(8'h00, "R10 hour 13"); expect_byte(8'h42, "R10 min"); expect_byte(8'h09, "R10 sec");
    read_cmd(8'hE6, 3);
    cal_hour = 8'h17;
    one[0] = 8'h40;
    write_cmd(8'h46, one, 1);

    // R8: date-time read order
    expect_byte(8'h24, "R8 year");  expect_byte(8'h07, "R8 month");
    expect_byte(8'h15, "R8 day");   expect_byte(8'h03, "R8 weekday");
    expect_byte(8'h17, "R8 hour");  expect_byte(8'h42, "R8 minute");
    expect_byte(8'h09, "R8 second");
    read_cmd(8'hA6, 7);

    // R9: time read
    expect_byte(8'h17, "R9 hour"); expect_byte(8'h42, "R9 minute"); expect_byte(8'h09, "R9 second");
    read_cmd(8'hE6, 3);

    // R6: bad marker and unused code
    reject_seen = 0;
    write_cmd(8'h00, one, 0);
    chk(reject_seen, "R6 bad marker rejected", reject_seen, 1);
    reject_seen = 0;
    write_cmd(8'h16, one, 0);
    chk(reject_seen, "R6 code 1 rejected", reject_seen, 1);
    expect_byte(8'h40, "R6 idle after reject");
    read_cmd(8'hC6, 1);

    // R12: discarded writes and no-op commands
    write_cmd(8'h26, seven, 7);
    write_cmd(8'h66, three, 3);
    write_cmd(8'h36, one, 0);
    write_cmd(8'h76, one, 0);
    expect_byte(8'h40, "R12 status untouched");
    read_cmd(8'hC6, 1);
    expect_byte(8'h17, "R12 time unchanged hour"); expect_byte(8'h42, "R12 minute"); expect_byte(8'h09, "R12 second");
    read_cmd(8'hE6, 3);

    // R13: select drop mid byte
    start_xfer();
    send_byte(8'h46);
    for (int i = 0; i < 4; i++) begin
      step(3'b100, 1);
      step(3'b101, 1);
    end
    end_xfer();
    expect_byte(8'h40, "R13 aborted write discarded");
    read_cmd(8'hC6, 1);

    // R2: readback positions and falling-edge-only data latch
    step(3'b011, 1);
    chk(pin_rdata == 3'b001, "R2 data not latched without fall", pin_rdata, 3'b001);
    step(3'b010, 1);
    chk(pin_rdata == 3'b010, "R2 data latched on fall", pin_rdata, 3'b010);
    step(3'b110, 1);
    chk(pin_rdata == 3'b110, "R2 select in bit 2", pin_rdata, 3'b110);
    start_xfer();
    end_xfer();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule